// File: doc/BRIEF.md
# Multi-Policy Float-to-Integer Converter

This block turns a binary32 or binary64 operand into a 32-bit or 64-bit integer, signed or unsigned, and returns the result in a 64-bit lane. A 3-bit mode selects one of three out-of-range policies. The first saturates and sends NaN to the minimum integer. The second saturates and sends NaN to zero. The third wraps modulo 2^N and sends NaN and infinities to zero. The low mode bit chooses between the caller's dynamic rounding direction and plain truncation.

The conversion datapath is combinational. It sits between an input register stage and an output register stage. An integer pipeline places one operand, with its width, sign and mode controls, on the inputs in each cycle. The result, an overflow indication and an illegal-mode flag follow two clock edges later. The overflow indication feeds the integer unit's summary-overflow and overflow status bits, which live outside this block.

Top module: `fcv_conv`

## Requirements
- R1: `mode[2:1]` selects the policy: 00 saturate with NaN to minimum, 01 saturate with NaN to zero, 10 wrap modulo 2^N. When `mode[0]` is 1 the block truncates toward zero. When it is 0 the block rounds in the direction given by `dyn_rnd`.
- R2: Modes 110 and 111 are illegal. They set `illegal` to 1, `result` to 0 and `ovf` to 0. Legal modes leave `illegal` at 0.
- R3: The `dyn_rnd` encodings are 00 nearest with ties to even, 01 toward zero, 10 toward +infinity and 11 toward -infinity.
- R4: Under both saturating policies, a rounded value at or above the destination maximum returns the maximum. A value at or below the minimum returns the minimum, and this includes infinities. For unsigned destinations the minimum is 0, so a negative value that rounds to a nonzero magnitude returns 0.
- R5: A NaN under policy 00 returns the minimum integer: 0x8000000000000000 for signed 64, 0xFFFFFFFF80000000 for signed 32, and 0 for unsigned. Under policy 01 a NaN returns 0.
- R6: Under the wrap policy, NaN and infinities return 0. Any other value is rounded and then reduced modulo 2^N, and the block returns that N-bit pattern.
- R7: `ovf` is 1 only when `ovf_en` is 1, the mode is legal, and the result does not equal the source value exactly. That covers a discarded fraction, a saturation or wrap, a NaN and an infinity.
- R8: When `src_single` is 1, `src_bits[31:0]` is read as binary32 (sign at bit 31, 8-bit exponent at 30:23) and bits 63:32 are ignored. Otherwise all 64 bits are read as binary64.
- R9: When `dst_wide` is 0, N is 32. Signed results are sign-extended from bit 31 and unsigned results have bits 63:32 at 0. When `dst_wide` is 1, N is 64.
- R10: Inputs are sampled on one rising edge and the outputs change on the next rising edge. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_bits | input | 64 | Floating-point operand bits |
| src_single | input | 1 | 1: operand is binary32 in bits 31:0 |
| dst_wide | input | 1 | 1: 64-bit destination, 0: 32-bit |
| dst_signed | input | 1 | 1: signed destination |
| mode | input | 3 | Policy (bits 2:1) and truncate select (bit 0) |
| dyn_rnd | input | 2 | Dynamic rounding direction |
| ovf_en | input | 1 | Enables the overflow indication |
| result | output | 64 | Integer result, extended to 64 bits |
| ovf | output | 1 | Inexact or out-of-range result with overflow enabled |
| illegal | output | 1 | Mode was 110 or 111 |

## Verification
The hardest cases to reach are values that sit exactly on a boundary: ties at one half under each rounding direction, magnitudes equal to 2^31 or 2^63, and negative fractions that round to zero or to minus one for unsigned destinations. Uniformly random bit patterns almost never land on these. The stimulus therefore draws exponents from a narrow window around the integer range, from just below one up to past 2^64, so that fractional, boundary and wrapping magnitudes all appear often. Directed operands are built for the exact edges, for the specials, and for a binary32 operand with garbage in the upper word.

// File: rtl/fcv_pkg.sv
package fcv_pkg;

  localparam int unsigned XW    = 64;
  localparam int unsigned NW    = XW / 2;
  localparam int unsigned DEXP  = 11;
  localparam int unsigned DFRAC = 52;
  localparam int unsigned SEXP  = 8;
  localparam int unsigned SFRAC = 23;
  localparam int unsigned MW    = DFRAC + 1;
  localparam int unsigned EW    = DEXP + 2;
  localparam int          DBIAS = (1 << (DEXP - 1)) - 1;
  localparam int          SBIAS = (1 << (SEXP - 1)) - 1;
  localparam int          HUGE_EXP = XW;

  typedef enum logic [1:0] {
    POL_SAT_MIN  = 2'b00,
    POL_SAT_ZERO = 2'b01,
    POL_WRAP     = 2'b10,
    POL_BAD      = 2'b11
  } policy_e;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_ZERO = 2'b01,
    RND_UP   = 2'b10,
    RND_DOWN = 2'b11
  } rnd_e;

  // operand decoded to sign, class and value = mant * 2^(exp - DFRAC)
  typedef struct packed {
    logic                 sign;
    logic                 nan;
    logic                 inf;
    logic signed [EW-1:0] exp;
    logic [MW-1:0]        mant;
  } fnum_t;

  // should the truncated magnitude be bumped by one
  function automatic logic round_up(rnd_e r, logic sign, logic lsb,
                                    logic guard, logic sticky);
    logic any;
    any = guard | sticky;
    case (r)
      RND_NEAR: return guard & (sticky | lsb);
      RND_UP:   return any & ~sign;
      RND_DOWN: return any & sign;
      default:  return 1'b0;
    endcase
  endfunction

  // largest magnitude allowed for a positive result
  function automatic logic [XW-1:0] pos_limit(logic wide, logic sgn);
    if (wide) return sgn ? {1'b0, {(XW-1){1'b1}}} : {XW{1'b1}};
    return sgn ? XW'({1'b0, {(NW-1){1'b1}}}) : XW'({NW{1'b1}});
  endfunction

  // largest magnitude allowed for a negative result
  function automatic logic [XW-1:0] neg_limit(logic wide, logic sgn);
    if (!sgn) return '0;
    return wide ? {1'b1, {(XW-1){1'b0}}} : XW'({1'b1, {(NW-1){1'b0}}});
  endfunction

  // bring a pattern to the destination width, then extend to XW
  function automatic logic [XW-1:0] fit_width(logic [XW-1:0] v, logic wide,
                                              logic sgn);
    if (wide) return v;
    return sgn ? {{NW{v[NW-1]}}, v[NW-1:0]} : {{NW{1'b0}}, v[NW-1:0]};
  endfunction

endpackage

// File: rtl/fcv_unpack.sv
module fcv_unpack
  import fcv_pkg::*;
(
  input  logic [XW-1:0] bits_i,
  input  logic          single_i,
  output fnum_t         num_o
);
  logic [SEXP-1:0]  s_ex;
  logic [SFRAC-1:0] s_fr;
  logic [DEXP-1:0]  d_ex;
  logic [DFRAC-1:0] d_fr;
  fnum_t            s_num, d_num;

  assign s_ex = bits_i[SFRAC +: SEXP];
  assign s_fr = bits_i[SFRAC-1:0];
  assign d_ex = bits_i[DFRAC +: DEXP];
  assign d_fr = bits_i[DFRAC-1:0];

  always_comb begin
    s_num.sign = bits_i[SEXP + SFRAC];
    s_num.nan  = (&s_ex) & (|s_fr);
    s_num.inf  = (&s_ex) & ~(|s_fr);
    s_num.exp  = (s_ex == '0) ? EW'(1 - SBIAS) : EW'(int'(s_ex) - SBIAS);
    s_num.mant = {(s_ex != '0), s_fr, {(DFRAC - SFRAC){1'b0}}};

    d_num.sign = bits_i[XW-1];
    d_num.nan  = (&d_ex) & (|d_fr);
    d_num.inf  = (&d_ex) & ~(|d_fr);
    d_num.exp  = (d_ex == '0) ? EW'(1 - DBIAS) : EW'(int'(d_ex) - DBIAS);
    d_num.mant = {(d_ex != '0), d_fr};
  end

  assign num_o = single_i ? s_num : d_num;
endmodule

// File: rtl/fcv_round.sv
module fcv_round
  import fcv_pkg::*;
(
  input  fnum_t         num_i,
  input  rnd_e          rnd_i,
  output logic [XW-1:0] mag_o,
  output logic          inexact_o,
  output logic          huge_o
);
  logic [XW-1:0] ipart;
  logic          guard, sticky;
  logic [EW-1:0] sh_dn, sh_up;
  logic [MW-1:0] below, half;

  assign sh_dn = EW'(DFRAC) - num_i.exp;
  assign sh_up = num_i.exp - EW'(DFRAC);
  assign below = (MW'(1) << sh_dn) - MW'(1);
  assign half  = (MW'(1) << sh_dn) >> 1;

  always_comb begin
    ipart  = '0;
    guard  = 1'b0;
    sticky = 1'b0;
    huge_o = 1'b0;
    if (num_i.exp < 0) begin
      // magnitude below one: only the half bit can be the hidden one
      guard  = (num_i.exp == -1) & num_i.mant[MW-1];
      sticky = (num_i.exp == -1) ? |num_i.mant[MW-2:0] : |num_i.mant;
    end else if (num_i.exp <= EW'(DFRAC)) begin
      ipart  = XW'(num_i.mant >> sh_dn);
      guard  = |(num_i.mant & half);
      sticky = |(num_i.mant & (below >> 1));
    end else begin
      // integral value; bits past XW fall away, which is the wrap residue
      ipart  = XW'(num_i.mant) << sh_up;
      huge_o = num_i.exp >= EW'(HUGE_EXP);
    end
  end

  assign mag_o     = ipart + XW'(round_up(rnd_i, num_i.sign, ipart[0], guard, sticky));
  assign inexact_o = guard | sticky;
endmodule

// File: rtl/fcv_policy.sv
module fcv_policy
  import fcv_pkg::*;
(
  input  policy_e       pol_i,
  input  logic          sign_i,
  input  logic          nan_i,
  input  logic          inf_i,
  input  logic [XW-1:0] mag_i,
  input  logic          huge_i,
  input  logic          wide_i,
  input  logic          sgn_i,
  output logic [XW-1:0] res_o,
  output logic          oor_o
);
  logic [XW-1:0] max_v, min_v, exact_v, sat_v, pick;

  assign max_v   = pos_limit(wide_i, sgn_i);
  assign min_v   = XW'(0) - neg_limit(wide_i, sgn_i);
  assign exact_v = sign_i ? (XW'(0) - mag_i) : mag_i;
  assign sat_v   = sign_i ? min_v : max_v;
  assign oor_o   = huge_i | (sign_i ? (mag_i > neg_limit(wide_i, sgn_i))
                                    : (mag_i > max_v));

  always_comb begin
    case (pol_i)
      POL_SAT_MIN:  pick = nan_i ? min_v : (inf_i | oor_o) ? sat_v : exact_v;
      POL_SAT_ZERO: pick = nan_i ? '0    : (inf_i | oor_o) ? sat_v : exact_v;
      POL_WRAP:     pick = (nan_i | inf_i) ? '0 : exact_v;
      default:      pick = '0;
    endcase
  end

  assign res_o = fit_width(pick, wide_i, sgn_i);
endmodule

// File: rtl/fcv_conv.sv
module fcv_conv
  import fcv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] src_bits,
  input  logic        src_single,
  input  logic        dst_wide,
  input  logic        dst_signed,
  input  logic [2:0]  mode,
  input  logic [1:0]  dyn_rnd,
  input  logic        ovf_en,
  output logic [63:0] result,
  output logic        ovf,
  output logic        illegal
);
  logic [XW-1:0] q_src;
  logic          q_single, q_wide, q_sgn, q_oen;
  logic [2:0]    q_mode;
  logic [1:0]    q_rnd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_src    <= '0;
      q_single <= 1'b0;
      q_wide   <= 1'b0;
      q_sgn    <= 1'b0;
      q_oen    <= 1'b0;
      q_mode   <= '0;
      q_rnd    <= '0;
    end else begin
      q_src    <= src_bits;
      q_single <= src_single;
      q_wide   <= dst_wide;
      q_sgn    <= dst_signed;
      q_oen    <= ovf_en;
      q_mode   <= mode;
      q_rnd    <= dyn_rnd;
    end
  end

  // named stage events, observed by the bound checker
  fnum_t         st_num;
  policy_e       st_pol;
  rnd_e          st_rnd;
  logic          st_legal, st_nan, st_inf, st_inexact, st_huge, st_oor, st_lost;
  logic [XW-1:0] st_mag, st_res;

  assign st_pol   = policy_e'(q_mode[2:1]);
  assign st_rnd   = q_mode[0] ? RND_ZERO : rnd_e'(q_rnd);
  assign st_legal = (st_pol != POL_BAD);

  fcv_unpack i_unpack (
    .bits_i   (q_src),
    .single_i (q_single),
    .num_o    (st_num)
  );

  fcv_round i_round (
    .num_i     (st_num),
    .rnd_i     (st_rnd),
    .mag_o     (st_mag),
    .inexact_o (st_inexact),
    .huge_o    (st_huge)
  );

  fcv_policy i_policy (
    .pol_i  (st_pol),
    .sign_i (st_num.sign),
    .nan_i  (st_num.nan),
    .inf_i  (st_num.inf),
    .mag_i  (st_mag),
    .huge_i (st_huge),
    .wide_i (q_wide),
    .sgn_i  (q_sgn),
    .res_o  (st_res),
    .oor_o  (st_oor)
  );

  assign st_nan  = st_num.nan;
  assign st_inf  = st_num.inf;
  assign st_lost = st_nan | st_inf | st_oor | st_inexact;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result  <= '0;
      ovf     <= 1'b0;
      illegal <= 1'b0;
    end else begin
      result  <= st_legal ? st_res : '0;
      ovf     <= st_legal & q_oen & st_lost;
      illegal <= ~st_legal;
    end
  end
endmodule

// File: rtl/fcv_conv_chk.sv
module fcv_conv_chk
  import fcv_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  mode,
  input logic        ovf_en,
  input logic        dst_wide,
  input logic        dst_signed,
  input logic [63:0] result,
  input logic        ovf,
  input logic        illegal,
  input policy_e     st_pol,
  input logic        st_legal,
  input logic        st_nan,
  input logic        st_inf,
  input logic        st_lost,
  input logic        q_oen
);
  p_illegal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[2:1] == 2'b11) |=> ##1 (illegal && result == '0 && !ovf));

  p_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[2:1] != 2'b11) |=> ##1 !illegal);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_en |=> ##1 !ovf);

  p_lost_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_legal && q_oen && st_lost) |=> ovf);

  p_exact_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !st_lost |=> !ovf);

  p_wrap_special_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_pol == POL_WRAP && (st_nan || st_inf)) |=> (result == '0));

  p_nan_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_pol == POL_SAT_ZERO && st_nan) |=> (result == '0));

  p_zero_ext_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dst_wide && !dst_signed) |=> ##1 (result[63:32] == '0));

  p_sign_ext_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dst_wide && dst_signed) |=> ##1
      (result[63:31] == '0 || result[63:31] == '1));
endmodule

bind fcv_conv fcv_conv_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .ovf_en     (ovf_en),
  .dst_wide   (dst_wide),
  .dst_signed (dst_signed),
  .result     (result),
  .ovf        (ovf),
  .illegal    (illegal),
  .st_pol     (st_pol),
  .st_legal   (st_legal),
  .st_nan     (st_nan),
  .st_inf     (st_inf),
  .st_lost    (st_lost),
  .q_oen      (q_oen)
);

// File: tb/test_fcv_conv.sv
module test_fcv_conv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_bits = '0;
  logic        src_single = 1'b0, dst_wide = 1'b0, dst_signed = 1'b0, ovf_en = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  dyn_rnd = '0;
  logic [63:0] result;
  logic        ovf, illegal;
  int          n_chk = 0, n_fail = 0;

  always #2ns clk = ~clk;

  fcv_conv i_fcv_conv (
    .clk(clk), .rst_n(rst_n), .src_bits(src_bits), .src_single(src_single),
    .dst_wide(dst_wide), .dst_signed(dst_signed), .mode(mode),
    .dyn_rnd(dyn_rnd), .ovf_en(ovf_en), .result(result), .ovf(ovf),
    .illegal(illegal)
  );

  // reference: value scaled by 2^64 into a wide fixed-point word
  function automatic void ref_conv(input logic [63:0] b, input logic sp,
      input logic wd, input logic sg, input logic [2:0] md,
      input logic [1:0] rn, input logic oe,
      output logic [63:0] r, output logic ov, output logic il);
    logic neg, nan, inf, huge, up, ok;
    logic [52:0] m;
    int e, s, n;
    logic [191:0] fx;
    logic [127:0] ip, mag, hi, lo;
    logic [63:0] fr, val, maxv, minv;
    if (sp) begin
      neg = b[31];
      nan = (b[30:23] == 8'hFF) && (b[22:0] != 0);
      inf = (b[30:23] == 8'hFF) && (b[22:0] == 0);
      m = (b[30:23] == 0) ? 53'(b[22:0]) : 53'({1'b1, b[22:0]});
      e = (b[30:23] == 0) ? -126 : int'(b[30:23]) - 127;
      s = e - 23 + 64;
    end else begin
      neg = b[63];
      nan = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
      inf = (b[62:52] == 11'h7FF) && (b[51:0] == 0);
      m = (b[62:52] == 0) ? 53'(b[51:0]) : {1'b1, b[51:0]};
      e = (b[62:52] == 0) ? -1022 : int'(b[62:52]) - 1023;
      s = e - 52 + 64;
    end
    huge = 1'b0;
    fx = '0;
    if (m != 0) begin
      if (s < 0) fx = 192'd1;
      else if (s > 139) huge = 1'b1;
      else fx = 192'(m) << s;
    end
    ip = fx[191:64];
    fr = fx[63:0];
    if (md[0]) up = 1'b0;
    else case (rn)
      2'b00: up = (fr > 64'h8000_0000_0000_0000) ||
                  (fr == 64'h8000_0000_0000_0000 && ip[0]);
      2'b10: up = !neg && fr != 0;
      2'b11: up = neg && fr != 0;
      default: up = 1'b0;
    endcase
    mag = ip + 128'(up);
    n = wd ? 64 : 32;
    if (sg) begin hi = (128'd1 << (n - 1)) - 1; lo = 128'd1 << (n - 1); end
    else    begin hi = (128'd1 << n) - 1;       lo = '0; end
    ok = !huge && (neg ? (mag <= lo) : (mag <= hi));
    maxv = hi[63:0];
    minv = 64'd0 - lo[63:0];
    val = neg ? 64'd0 - mag[63:0] : mag[63:0];
    il = (md[2:1] == 2'b11);
    case (md[2:1])
      2'b00: r = nan ? minv : (inf || !ok) ? (neg ? minv : maxv) : val;
      2'b01: r = nan ? 64'd0 : (inf || !ok) ? (neg ? minv : maxv) : val;
      2'b10: r = (nan || inf) ? 64'd0 : val;
      default: r = 64'd0;
    endcase
    if (!wd) r = sg ? {{32{r[31]}}, r[31:0]} : {32'd0, r[31:0]};
    ov = !il && oe && (nan || inf || !ok || fr != 0);
  endfunction

  task automatic check(input string tag, input logic [63:0] er,
                       input logic eo, input logic ei);
    n_chk++;
    if (result !== er || ovf !== eo || illegal !== ei) begin
      n_fail++;
      $display("FAIL %s: result=%h ovf=%b illegal=%b, expected result=%h ovf=%b illegal=%b",
               tag, result, ovf, illegal, er, eo, ei);
    end
  endtask

  task automatic run(input string tag, input logic [63:0] b, input logic sp,
      input logic wd, input logic sg, input logic [2:0] md,
      input logic [1:0] rn, input logic oe);
    logic [63:0] er;
    logic eo, ei;
    @(negedge clk);
    src_bits = b; src_single = sp; dst_wide = wd; dst_signed = sg;
    mode = md; dyn_rnd = rn; ovf_en = oe;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    ref_conv(b, sp, wd, sg, md, rn, oe, er, eo, ei);
    check(tag, er, eo, ei);
  endtask

  localparam logic [63:0] D_ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] D_1P5  = 64'h3FF8_0000_0000_0000;
  localparam logic [63:0] D_2P5  = 64'h4004_0000_0000_0000;
  localparam logic [63:0] D_M2P5 = 64'hC004_0000_0000_0000;
  localparam logic [63:0] D_3    = 64'h4008_0000_0000_0000;
  localparam logic [63:0] D_3P5  = 64'h400C_0000_0000_0000;
  localparam logic [63:0] D_NAN  = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] D_PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] D_MINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] D_2E31 = 64'h41E0_0000_0000_0000;
  localparam logic [63:0] D_2E63 = 64'h43E0_0000_0000_0000;
  localparam logic [63:0] D_M2E63 = 64'hC3E0_0000_0000_0000;
  localparam logic [63:0] D_2E64 = 64'h43F0_0000_0000_0000;
  localparam logic [63:0] D_BIG5 = 64'h41F0_0000_0050_0000;
  localparam logic [63:0] D_MBIG5 = 64'hC1F0_0000_0050_0000;
  localparam logic [63:0] D_M0P3 = 64'hBFD3_3333_3333_3333;
  localparam logic [63:0] D_MONE = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] D_MTWO = 64'hC000_0000_0000_0000;

  initial begin
    #800us;
    n_fail++;
    n_chk++;
    $display("FAIL R10: watchdog expired, actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset clears outputs", 64'd0, 1'b0, 1'b0);
    rst_n = 1'b1;

    // R1 policy and truncate select
    run("R1 sat dyn 2.5", D_2P5, 0, 1, 1, 3'b000, 2'b00, 1);
    run("R1 sat trunc 3.5", D_3P5, 0, 1, 1, 3'b001, 2'b00, 1);
    run("R1 nan-zero dyn 3.5", D_3P5, 0, 1, 1, 3'b010, 2'b00, 0);
    run("R1 nan-zero trunc 3.5", D_3P5, 0, 1, 1, 3'b011, 2'b10, 0);
    run("R1 wrap trunc -2.5", D_M2P5, 0, 1, 1, 3'b101, 2'b11, 1);
    // R3 dynamic rounding directions
    run("R3 near tie even 2.5", D_2P5, 0, 1, 1, 3'b000, 2'b00, 0);
    run("R3 near tie odd 1.5", D_1P5, 0, 1, 1, 3'b000, 2'b00, 0);
    run("R3 toward zero 2.5", D_2P5, 0, 1, 1, 3'b000, 2'b01, 0);
    run("R3 toward +inf 2.5", D_2P5, 0, 1, 1, 3'b000, 2'b10, 0);
    run("R3 toward -inf -2.5", D_M2P5, 0, 1, 1, 3'b000, 2'b11, 0);
    run("R3 toward +inf -2.5", D_M2P5, 0, 1, 1, 3'b000, 2'b10, 0);
    // R4 saturation edges
    run("R4 2^63 to signed64", D_2E63, 0, 1, 1, 3'b000, 2'b00, 1);
    run("R4 -2^63 exact min", D_M2E63, 0, 1, 1, 3'b000, 2'b00, 1);
    run("R4 2^64 to unsigned64", D_2E64, 0, 1, 0, 3'b011, 2'b00, 1);
    run("R4 2^31 to signed32", D_2E31, 0, 0, 1, 3'b000, 2'b00, 1);
    run("R4 +inf sat", D_PINF, 0, 1, 1, 3'b010, 2'b00, 1);
    run("R4 -inf sat", D_MINF, 0, 0, 1, 3'b000, 2'b00, 1);
    run("R4 -0.3 trunc unsigned", D_M0P3, 0, 1, 0, 3'b001, 2'b00, 1);
    run("R4 -0.3 down unsigned", D_M0P3, 0, 0, 0, 3'b000, 2'b11, 1);
    // R5 NaN handling
    run("R5 nan min signed64", D_NAN, 0, 1, 1, 3'b000, 2'b00, 1);
    run("R5 nan min signed32", D_NAN, 0, 0, 1, 3'b001, 2'b00, 1);
    run("R5 nan min unsigned", D_NAN, 0, 1, 0, 3'b000, 2'b00, 1);
    run("R5 nan to zero", D_NAN, 0, 1, 1, 3'b010, 2'b00, 1);
    // R6 wrap
    run("R6 wrap 2^32+5 signed32", D_BIG5, 0, 0, 1, 3'b101, 2'b00, 1);
    run("R6 wrap -(2^32+5) unsigned32", D_MBIG5, 0, 0, 0, 3'b100, 2'b00, 1);
    run("R6 wrap 2^64", D_2E64, 0, 1, 1, 3'b100, 2'b00, 1);
    run("R6 wrap 2^63 signed64", D_2E63, 0, 1, 1, 3'b101, 2'b00, 1);
    run("R6 wrap nan", D_NAN, 0, 1, 1, 3'b100, 2'b00, 1);
    run("R6 wrap -inf", D_MINF, 0, 0, 1, 3'b101, 2'b00, 1);
    // R7 overflow enable
    run("R7 nan with overflow off", D_NAN, 0, 1, 1, 3'b000, 2'b00, 0);
    run("R7 exact one quiet", D_ONE, 0, 1, 1, 3'b000, 2'b00, 1);
    run("R7 inexact 2.5 flags", D_2P5, 0, 1, 1, 3'b001, 2'b00, 1);
    // R8 single source, upper word ignored
    run("R8 single 1.5 garbage top", 64'hDEAD_BEEF_3FC0_0000, 1, 1, 1, 3'b000, 2'b00, 1);
    run("R8 single -1.0", 64'h1234_5678_BF80_0000, 1, 0, 1, 3'b000, 2'b00, 1);
    run("R8 single nan", 64'h0000_0000_7FC0_0000, 1, 1, 1, 3'b000, 2'b00, 1);
    // R9 narrow extension
    run("R9 -1 signed32", D_MONE, 0, 0, 1, 3'b000, 2'b00, 0);
    run("R9 -2 wrap unsigned32", D_MTWO, 0, 0, 0, 3'b100, 2'b00, 0);
    run("R9 3 signed32", D_3, 0, 0, 1, 3'b000, 2'b00, 0);
    // R2 illegal modes
    run("R2 mode 110", D_NAN, 0, 1, 1, 3'b110, 2'b00, 1);
    run("R2 mode 111", D_2P5, 0, 0, 1, 3'b111, 2'b00, 1);

    // R10 latency: output holds for one edge, then updates
    run("R10 first operand", D_ONE, 0, 1, 1, 3'b000, 2'b00, 0);
    @(negedge clk);
    src_bits = D_3;
    @(posedge clk);
    @(negedge clk);
    check("R10 output held one edge", 64'd1, 1'b0, 1'b0);
    @(posedge clk);
    @(negedge clk);
    check("R10 output after two edges", 64'd3, 1'b0, 1'b0);

    // random operands around the integer range
    for (int i = 0; i < 600; i++) begin
      logic [63:0] b;
      logic sp;
      int unsigned pick;
      pick = $urandom % 100;
      sp = ($urandom % 4) == 0;
      if (sp) begin
        b = {$urandom, 1'b0, 8'(127 + ($urandom % 72) - 8), 23'($urandom)};
        b[31] = $urandom % 2;
        if (pick < 4) b[30:23] = 8'hFF;
        if (pick == 4) b[30:0] = '0;
      end else begin
        b = {1'($urandom), 11'(1023 + ($urandom % 80) - 8),
             32'($urandom), 20'($urandom)};
        if (pick < 4) b[62:52] = 11'h7FF;
        if (pick == 4) b[51:0] = '0;
        if (pick == 5) b[62:52] = '0;
        if (pick > 90) b[40:0] = '0;
      end
      run("R1 R3 R4 R6 R7 random", b, sp, 1'($urandom), 1'($urandom),
          3'($urandom % 8), 2'($urandom), 1'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule